// File: doc/BRIEF.md
# Effective Address Resolution Unit

This unit works out the final operand address of a memory-reference instruction for a 16-bit, word-addressed processor with a 16K-word (14-bit) address space. On a start pulse it captures the instruction word, the program counter, a base-sector number and the index register. It then forms a first address in one of two ways. A clear sector bit places the 9-bit offset in the base sector. A set sector bit places the offset in the sector that holds the current instruction. A set tag bit adds the index register to that address.

If the instruction's flag bit is set, the unit reads the word at that address through a synchronous read port with a one-cycle latency. The word read is an indirect pointer:

- bits 13..0 give a full 14-bit address;
- bit 14 asks for indexing of that address;
- bit 15 asks for another level of indirection.

The unit keeps reading until it fetches a word with a clear flag bit. There is no limit on the number of levels. The final address is presented on `ea` together with a one-cycle `done` pulse. `ea` then holds that value until the next resolution completes.

The execution logic of the processor drives the unit. It raises `start` only when the unit is idle, and it uses `ea` when `done` is seen.

Top module: `ea_resolver`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` and `mem_req` are 0 and `ea` is 0.
- R2: When the instruction has flag (bit 15), tag (bit 14) and sector (bit 9) all clear, the result is `{base_sect, instr[8:0]}`. The base-sector input relocates the result to any of the 32 sectors.
- R3: When the sector bit (bit 9) is set and flag and tag are clear, the result is `{pc[13:9], instr[8:0]}`.
- R4: When the instruction's tag bit (bit 14) is set, the low 14 bits of the index register are added to the sector-formed address, modulo 2^14.
- R5: When the instruction's flag bit (bit 15) is set, the first memory read goes to the address formed after indexing. That is, indexing happens before indirection. `mem_addr` is held through the cycle after the request.
- R6: In each fetched indirect word, bits 13..0 are the next address. A set bit 14 adds the index register to that address, modulo 2^14. A set bit 15 starts another read at the result. A clear bit 15 makes the result final. Chains of any depth are followed.
- R7: `done` rises exactly 1 + 2·L cycles after the clock edge that accepts `start`, where L is the number of indirect reads. `done` lasts one cycle, and `ea` changes only in the cycle where `done` is high.
- R8: All inputs are sampled only at the edge that accepts `start`, in the idle state. A `start` or input change while a resolution is in progress has no effect on its result or timing, and it produces no extra `done`.
- R9: Exactly one `mem_req` is issued per indirect level, never in two consecutive cycles, and none for a direct address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resolution (accepted when idle) |
| instr | input | 16 | Instruction word |
| pc | input | 14 | Address of the current instruction |
| base_sect | input | 5 | Sector number used when the sector bit is clear |
| idx | input | 14 | Index register value |
| mem_req | output | 1 | Read request for one indirect word |
| mem_addr | output | 14 | Read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_req` |
| done | output | 1 | One-cycle pulse: `ea` holds the new result |
| ea | output | 14 | Effective address |

## Verification
A corrupted pointer or index register shows up as a wrong `ea` on the `done` pulse, or as a wrong `mem_addr` on the next read, within two cycles of the fault. A wrong state sequence shows up as a change in latency or in the number of reads per resolution. The bench checks both for chains of zero to three levels, with and without tagged indirect words. Ordering faults are caught because the test vectors were chosen so that indexing after indirection, or taking the wrong sector, reads a different word and gives a different result.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int ADDR_W = 14;
    localparam int WORD_W = 16;
    localparam int OFFS_W = 9;
    localparam int SECT_W = ADDR_W - OFFS_W;
    localparam int OP_W   = WORD_W - 3 - OFFS_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SECT_W-1:0] sect_t;

    typedef struct packed {
        logic              flag;
        logic              tag;
        logic [OP_W-1:0]   op;
        logic              sect;
        logic [OFFS_W-1:0] offs;
    } instr_t;

    typedef struct packed {
        logic  flag;
        logic  tag;
        addr_t ptr;
    } ind_t;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_REQ  = 2'd1,
        W_RESP = 2'd2,
        W_DONE = 2'd3
    } walk_st_t;

    function automatic addr_t add_index(input addr_t a, input addr_t x, input logic en);
        return en ? addr_t'(a + x) : a;
    endfunction
endpackage

// File: rtl/ea_seed.sv
module ea_seed
    import ea_pkg::*;
(
    input  word_t instr_w,
    input  addr_t pc,
    input  sect_t base_sect,
    input  addr_t idx,
    output addr_t seed,
    output logic  seed_ind
);
    instr_t ins;
    sect_t  sect_sel;

    always_comb begin
        ins      = instr_t'(instr_w);
        sect_sel = ins.sect ? pc[ADDR_W-1:OFFS_W] : base_sect;
        seed     = add_index({sect_sel, ins.offs}, idx, ins.tag);
        seed_ind = ins.flag;
    end
endmodule

// File: rtl/ea_step.sv
module ea_step
    import ea_pkg::*;
(
    input  word_t rdata,
    input  addr_t idx,
    output addr_t next_addr,
    output logic  more
);
    ind_t w;

    always_comb begin
        w         = ind_t'(rdata);
        next_addr = add_index(w.ptr, idx, w.tag);
        more      = w.flag;
    end
endmodule

// File: rtl/ea_walk.sv
module ea_walk
    import ea_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  addr_t seed,
    input  logic  seed_ind,
    input  addr_t idx_in,
    input  addr_t step_addr,
    input  logic  step_more,
    output addr_t idx_q,
    output logic  mem_req,
    output addr_t mem_addr,
    output logic  done,
    output addr_t ea
);
    walk_st_t st;
    addr_t    ptr_q;
    addr_t    ea_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= W_IDLE;
            ptr_q <= '0;
            idx_q <= '0;
            ea_q  <= '0;
        end else begin
            case (st)
                W_IDLE: if (start) begin
                    idx_q <= idx_in;
                    if (seed_ind) begin
                        ptr_q <= seed;
                        st    <= W_REQ;
                    end else begin
                        ea_q <= seed;
                        st   <= W_DONE;
                    end
                end
                W_REQ:  st <= W_RESP;
                W_RESP: if (step_more) begin
                    ptr_q <= step_addr;
                    st    <= W_REQ;
                end else begin
                    ea_q <= step_addr;
                    st   <= W_DONE;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    assign mem_req  = (st == W_REQ);
    assign mem_addr = ptr_q;
    assign done     = (st == W_DONE);
    assign ea       = ea_q;

    // R9: a read needs its response cycle before the next one
    p_req_spaced_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R5: read address held while the data comes back
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> $stable(mem_addr));
    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: result only moves together with done
    p_ea_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ea));
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [WORD_W-1:0]       instr,
    input  logic [ADDR_W-1:0]       pc,
    input  logic [SECT_W-1:0]       base_sect,
    input  logic [ADDR_W-1:0]       idx,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic                    done,
    output logic [ADDR_W-1:0]       ea
);
    addr_t seed, step_addr, idx_q;
    logic  seed_ind, step_more;

    ea_seed u_seed (
        .instr_w  (instr),
        .pc       (pc),
        .base_sect(base_sect),
        .idx      (idx),
        .seed     (seed),
        .seed_ind (seed_ind)
    );

    ea_step u_step (
        .rdata    (mem_rdata),
        .idx      (idx_q),
        .next_addr(step_addr),
        .more     (step_more)
    );

    ea_walk u_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .seed     (seed),
        .seed_ind (seed_ind),
        .idx_in   (idx),
        .step_addr(step_addr),
        .step_more(step_more),
        .idx_q    (idx_q),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .done     (done),
        .ea       (ea)
    );
endmodule

// File: tb/test_ea_resolver.sv
`timescale 1ns/1ps
module test_ea_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [13:0] pc = '0;
    logic [4:0]  base_sect = '0;
    logic [13:0] idx = '0;
    logic        mem_req;
    logic [13:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic [13:0] ea;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ea_resolver i_ea_resolver (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc(pc),
        .base_sect(base_sect), .idx(idx), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .ea(ea)
    );

    logic [15:0] mem [int];

    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
    end

    typedef struct packed {
        logic [15:0] instr;
        logic [13:0] pc;
        logic [4:0]  base;
        logic [13:0] idx;
        logic [13:0] ea;
        logic [3:0]  lv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0855, 14'h1234, 5'h00, 14'h0005, 14'h0055, 4'd0}, // R2 base sector 0
        '{16'h0855, 14'h1234, 5'h07, 14'h0005, 14'h0E55, 4'd0}, // R2 relocated
        '{16'h0AAA, 14'h3456, 5'h03, 14'h0005, 14'h34AA, 4'd0}, // R3 current sector
        '{16'h4810, 14'h1234, 5'h00, 14'h0025, 14'h0035, 4'd0}, // R4 indexed
        '{16'h4BFF, 14'h3E00, 5'h00, 14'h0201, 14'h0200, 4'd0}, // R4 wrap
        '{16'h8900, 14'h0000, 5'h00, 14'h0010, 14'h1ABC, 4'd1}, // R5 one level
        '{16'hC8F0, 14'h0000, 5'h00, 14'h0010, 14'h1ABC, 4'd1}, // R5 index first
        '{16'h8901, 14'h0000, 5'h00, 14'h0010, 14'h000F, 4'd2}, // R6 tagged words
        '{16'h8902, 14'h0000, 5'h00, 14'h0000, 14'h0777, 4'd3}, // R6 three levels
        '{16'h8800, 14'h0000, 5'h01, 14'h0000, 14'h2ABC, 4'd1}  // R5 relocated indirect
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R2";
            2:       return "R3";
            3, 4:    return "R4";
            5, 6, 9: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one resolution. Returns cycles to done, requests seen, back-to-back requests.
    task automatic run(input vec_t v, input bit disturb,
                       output int cyc, output int reqs, output int b2b);
        bit prev_req = 1'b0;
        @(negedge clk);
        instr = v.instr; pc = v.pc; base_sect = v.base; idx = v.idx; start = 1'b1;
        cyc = 0; reqs = 0; b2b = 0;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (disturb && cyc == 1) begin
                instr = 16'h0855; pc = 14'h3FFF; base_sect = 5'h1F; idx = 14'h0099; start = 1'b1;
            end
            if (mem_req) begin
                reqs++;
                if (prev_req) b2b++;
            end
            prev_req = mem_req;
            if (done) break;
        end
        start = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cyc, reqs, b2b, extra;
        mem[32'h0100] = 16'h1ABC;
        mem[32'h0101] = 16'hC200;
        mem[32'h0210] = 16'h7FFF;
        mem[32'h0102] = 16'h8300;
        mem[32'h0300] = 16'h8301;
        mem[32'h0301] = 16'h0777;
        mem[32'h0200] = 16'h2ABC;

        repeat (3) @(negedge clk);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "mem_req in reset", int'(mem_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "ea after reset", int'(ea), 0);
        check("R1", "done after reset", int'(done), 0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], 1'b0, cyc, reqs, b2b);
            check(tag_of(i), $sformatf("vec %0d ea", i), int'(ea), int'(VECS[i].ea));
            check("R7", $sformatf("vec %0d latency", i), cyc, 1 + 2 * int'(VECS[i].lv));
            check("R9", $sformatf("vec %0d reads", i), reqs, int'(VECS[i].lv));
            check("R9", $sformatf("vec %0d back-to-back", i), b2b, 0);
        end

        // R7: ea holds after the pulse
        @(negedge clk);
        check("R7", "done one cycle", int'(done), 0);
        check("R7", "ea held", int'(ea), 16'h2ABC & 14'h3FFF);

        // R8: start and input changes during a walk have no effect
        run(VECS[8], 1'b1, cyc, reqs, b2b);
        check("R8", "ea with disturbance", int'(ea), 14'h0777);
        check("R8", "latency with disturbance", cyc, 7);
        extra = 0;
        repeat (4) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R8", "no extra done", extra, 0);

        // R8: index captured at start, not later (tagged chain)
        run(VECS[7], 1'b1, cyc, reqs, b2b);
        check("R8", "index captured at start", int'(ea), 14'h000F);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule